// File: doc/BRIEF.md
# Programmable Serial Datagram Bit Assembler

This block builds the serial control word for a daisy chain of stepper driver chips and sends it over an SPI master link. Each chip in the chain gets, per coil, a decay-mode bit, the upper four bits of a current amplitude and a phase bit. Which of these goes out at each position is not fixed. A 64-entry source table gives a 4-bit source code for every transmitted position. A special code moves the data source from one motor's inputs to the next motor's inputs and puts nothing on the wire. Another code ends the datagram. Chips are told apart only by their position in the chain. For example, a three-chip chain with six bits per coil takes 36 transmitted bits.

A one-cycle `start` pulse captures the per-motor inputs (phase, amplitude and decay bits) into a snapshot. It then drives chip select low and walks the table. Each selected bit is shifted out MSB-of-chain first in table order. After the last bit, chip select is raised, and that rising edge latches every chip's shift register into its outputs. A host port reads and writes the table one pair of adjacent entries at a time. To change a single entry, the host reads the pair, edits it and writes it back.

The host port has no back-pressure. A write or read request is taken in the cycle it is raised, and read data always returns exactly one cycle later with `tbl_rvalid`. Because the stream leaves on SPI pins, there is no valid/ready pair there. The datagram is paced only by `start` and `busy`.

Top module: `dgasm_top`

## Requirements
- R1: Source codes are: 0 constant zero, 1 constant one, 2 phase of coil A, 3 phase of coil B, 4 decay bit of coil A, 5 decay bit of coil B, 14 advance-motor, 15 end. Motor-dependent codes read the current motor's snapshot. Constant codes give their value whatever the current motor is.
- R2: Code 14 advances the current motor by one and creates no SCK edge and no data bit. Motor-dependent codes used after the last motor has been passed yield 0.
- R3: Walking stops at the first code 15, or after entry 63 if no code 15 is found. Entries after a code 15 have no effect on the wire.
- R4: Codes 6..9 send amplitude bits 2..5 of coil A, and codes 10..13 send amplitude bits 2..5 of coil B. For the 6-bit amplitude default, code 6+k sends bit 2+k. The two lowest amplitude bits are never sent.
- R5: SCK is low whenever chip select is high. SDO changes only while SCK is low, and it holds its value in the cycle SCK rises and through the whole high phase.
- R6: Chip select falls in the clock after an accepted start and stays low for at least HALF_PERIOD cycles before the first SCK rise. It rises exactly once per datagram, with SCK low. This includes a datagram with no bits.
- R7: `busy` rises in the cycle after an accepted start and falls in the same cycle that chip select rises. A start while `busy` is high is ignored.
- R8: A host write to pair k stores `tbl_wdata[3:0]` into entry 2k and `tbl_wdata[7:4]` into entry 2k+1, and leaves every other entry unchanged.
- R9: A host read of pair k returns entry 2k in bits [3:0] and entry 2k+1 in bits [7:4] one cycle later, with `tbl_rvalid` high for exactly that cycle.
- R10: Motor inputs are sampled when start is accepted. Changes to them during the datagram do not affect the bits sent.
- R11: After reset every table entry holds code 15, chip select is high, and SCK, SDO and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send a datagram |
| busy | output | 1 | Datagram in progress |
| phase_a | input | NUM_MOTORS | Coil A phase bit per motor |
| phase_b | input | NUM_MOTORS | Coil B phase bit per motor |
| fdec_a | input | NUM_MOTORS | Coil A decay-mode bit per motor |
| fdec_b | input | NUM_MOTORS | Coil B decay-mode bit per motor |
| dac_a | input | NUM_MOTORS*DAC_W | Coil A amplitude, motor m at bits [m*DAC_W +: DAC_W] |
| dac_b | input | NUM_MOTORS*DAC_W | Coil B amplitude, same packing |
| tbl_wr | input | 1 | Write a table pair |
| tbl_rd | input | 1 | Read a table pair |
| tbl_pair | input | log2(TBL_DEPTH/2) | Pair index |
| tbl_wdata | input | 8 | Pair write data |
| tbl_rdata | output | 8 | Pair read data |
| tbl_rvalid | output | 1 | Read data valid |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench sweeps every transmitting code against every motor slot, including a slot past the last motor. A wrong source mapping there sends the wrong bit, and a missing guard sends a stale motor's bit instead of 0. It runs the full 36-bit three-chip layout with tied and live decay bits under several input patterns. A design that clocks the advance code, or fails to advance, comes out with the wrong bit count or with shifted bits. It also covers a table with no end code, and an end code followed by non-end entries. A design that reads past the end or stops early gives the wrong length. Finally, it changes the inputs and pulses start in the middle of a datagram, and it does a read-modify-write of a single entry. These show whether the snapshot is taken, whether a repeated start is ignored, and whether writes land on the correct half of a pair.

// File: rtl/dgasm_pkg.sv
package dgasm_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    SRC_ZERO = 4'd0,
    SRC_ONE  = 4'd1,
    SRC_PHA  = 4'd2,
    SRC_PHB  = 4'd3,
    SRC_FDA  = 4'd4,
    SRC_FDB  = 4'd5,
    SRC_DA2  = 4'd6,
    SRC_DA3  = 4'd7,
    SRC_DA4  = 4'd8,
    SRC_DA5  = 4'd9,
    SRC_DB2  = 4'd10,
    SRC_DB3  = 4'd11,
    SRC_DB4  = 4'd12,
    SRC_DB5  = 4'd13,
    SRC_NEXT = 4'd14,
    SRC_END  = 4'd15
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_st_e;

endpackage

// File: rtl/dga_table.sv
module dga_table
  import dgasm_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [$clog2(DEPTH/2)-1:0]    pair_idx,
  input  logic [2*CODE_W-1:0]           wdata,
  output logic [2*CODE_W-1:0]           rdata,
  output logic                          rvalid,
  input  logic [$clog2(DEPTH)-1:0]      seq_idx,
  output src_e                          seq_code
);

  localparam int PAIRS = DEPTH / 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic [2*CODE_W-1:0] pair_q [PAIRS];
  logic [2*CODE_W-1:0] seq_pair;

  // Host side: pair-granular writes, registered pair reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAIRS; p++) pair_q[p] <= {2{SRC_END}};
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (wr_en) pair_q[pair_idx] <= wdata;
      rvalid <= rd_en;
      if (rd_en) rdata <= pair_q[pair_idx];
    end
  end

  // Sequencer side: single-entry combinational read.
  assign seq_pair = pair_q[seq_idx[IDX_W-1:1]];
  assign seq_code = src_e'(seq_idx[0] ? seq_pair[2*CODE_W-1:CODE_W]
                                      : seq_pair[CODE_W-1:0]);

endmodule

// File: rtl/dga_bitsel.sv
module dga_bitsel
  import dgasm_pkg::*;
#(
  parameter int M      = 3,
  parameter int DAC_W  = 6,
  parameter int MIDX_W = 2
) (
  input  src_e                  code,
  input  logic [MIDX_W-1:0]     motor,
  input  logic [M-1:0]          ph_a,
  input  logic [M-1:0]          ph_b,
  input  logic [M-1:0]          fd_a,
  input  logic [M-1:0]          fd_b,
  input  logic [M*DAC_W-1:0]    da,
  input  logic [M*DAC_W-1:0]    db,
  output logic                  bit_o
);

  localparam int SENT = 4;
  localparam int LOSB = DAC_W - SENT;

  // One 16-wide lane per motor, indexed directly by the source code.
  logic [15:0] lane [M];

  for (genvar m = 0; m < M; m++) begin : g_lane
    assign lane[m] = {2'b00,
                      db[m*DAC_W+LOSB +: SENT],
                      da[m*DAC_W+LOSB +: SENT],
                      fd_b[m], fd_a[m], ph_b[m], ph_a[m],
                      1'b1, 1'b0};
  end

  always_comb begin
    bit_o = 1'b0;
    for (int m = 0; m < M; m++) begin
      if (motor == MIDX_W'(m)) bit_o = lane[m][code];
    end
    if (code == SRC_ZERO) bit_o = 1'b0;
    if (code == SRC_ONE)  bit_o = 1'b1;
  end

endmodule

// File: rtl/dga_seq.sv
module dga_seq
  import dgasm_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int M      = 3,
  parameter int HALF   = 2,
  parameter int MIDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  src_e                      code,
  input  logic                      bit_i,
  output logic [$clog2(DEPTH)-1:0]  idx_o,
  output logic [MIDX_W-1:0]         motor_o,
  output logic                      launch_o,
  output logic                      busy_o,
  output logic                      cs_n_o,
  output logic                      sck_o,
  output logic                      sdo_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int CNT_W = $clog2(HALF + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  seq_st_e          st_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ptr_done;

  assign idx_o    = ptr_q[IDX_W-1:0];
  assign ptr_done = (ptr_q == PTR_W'(DEPTH));
  assign busy_o   = (st_q != ST_IDLE);
  assign launch_o = start && (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      motor_o <= '0;
      cs_n_o  <= 1'b1;
      sck_o   <= 1'b0;
      sdo_o   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            cs_n_o  <= 1'b0;
            ptr_q   <= '0;
            motor_o <= '0;
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (ptr_done || code == SRC_END) begin
            cnt_q <= '0;
            st_q  <= ST_TAIL;
          end else if (code == SRC_NEXT) begin
            ptr_q <= ptr_q + PTR_W'(1);
            if (motor_o != MIDX_W'(M)) motor_o <= motor_o + MIDX_W'(1);
          end else begin
            sdo_o <= bit_i;
            ptr_q <= ptr_q + PTR_W'(1);
            cnt_q <= '0;
            st_q  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (cnt_q == CNT_LAST) begin
            sck_o <= 1'b1;
            cnt_q <= '0;
            st_q  <= ST_HIGH;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (cnt_q == CNT_LAST) begin
            sck_o <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_FETCH;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_TAIL: begin
          if (cnt_q == CNT_LAST) begin
            cs_n_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dgasm_top.sv
module dgasm_top
  import dgasm_pkg::*;
#(
  parameter int NUM_MOTORS  = 3,
  parameter int DAC_W       = 6,
  parameter int TBL_DEPTH   = 64,
  parameter int HALF_PERIOD = 2,
  localparam int PAIR_W     = $clog2(TBL_DEPTH / 2),
  localparam int IDX_W      = $clog2(TBL_DEPTH),
  localparam int MIDX_W     = $clog2(NUM_MOTORS + 1),
  localparam int DACS_W     = NUM_MOTORS * DAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  input  logic [NUM_MOTORS-1:0] phase_a,
  input  logic [NUM_MOTORS-1:0] phase_b,
  input  logic [NUM_MOTORS-1:0] fdec_a,
  input  logic [NUM_MOTORS-1:0] fdec_b,
  input  logic [DACS_W-1:0]     dac_a,
  input  logic [DACS_W-1:0]     dac_b,
  input  logic                  tbl_wr,
  input  logic                  tbl_rd,
  input  logic [PAIR_W-1:0]     tbl_pair,
  input  logic [2*CODE_W-1:0]   tbl_wdata,
  output logic [2*CODE_W-1:0]   tbl_rdata,
  output logic                  tbl_rvalid,
  output logic                  spi_sck,
  output logic                  spi_sdo,
  output logic                  spi_cs_n
);

  logic [NUM_MOTORS-1:0] s_pha, s_phb, s_fda, s_fdb;
  logic [DACS_W-1:0]     s_da, s_db;
  logic [IDX_W-1:0]      seq_idx;
  logic [MIDX_W-1:0]     motor;
  src_e                  code;
  logic                  sel_bit;
  logic                  launch;

  // Input snapshot taken when a datagram is launched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pha <= '0; s_phb <= '0; s_fda <= '0; s_fdb <= '0;
      s_da  <= '0; s_db  <= '0;
    end else if (launch) begin
      s_pha <= phase_a; s_phb <= phase_b;
      s_fda <= fdec_a;  s_fdb <= fdec_b;
      s_da  <= dac_a;   s_db  <= dac_b;
    end
  end

  dga_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr),
    .rd_en    (tbl_rd),
    .pair_idx (tbl_pair),
    .wdata    (tbl_wdata),
    .rdata    (tbl_rdata),
    .rvalid   (tbl_rvalid),
    .seq_idx  (seq_idx),
    .seq_code (code)
  );

  dga_bitsel #(.M(NUM_MOTORS), .DAC_W(DAC_W), .MIDX_W(MIDX_W)) u_sel (
    .code  (code),
    .motor (motor),
    .ph_a  (s_pha),
    .ph_b  (s_phb),
    .fd_a  (s_fda),
    .fd_b  (s_fdb),
    .da    (s_da),
    .db    (s_db),
    .bit_o (sel_bit)
  );

  dga_seq #(.DEPTH(TBL_DEPTH), .M(NUM_MOTORS), .HALF(HALF_PERIOD),
            .MIDX_W(MIDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .code     (code),
    .bit_i    (sel_bit),
    .idx_o    (seq_idx),
    .motor_o  (motor),
    .launch_o (launch),
    .busy_o   (busy),
    .cs_n_o   (spi_cs_n),
    .sck_o    (spi_sck),
    .sdo_o    (spi_sdo)
  );

endmodule

// File: rtl/dgasm_chk.sv
module dgasm_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic tbl_rd,
  input logic tbl_rvalid,
  input logic spi_sck,
  input logic spi_sdo,
  input logic spi_cs_n
);

  // R5
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_sdo));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (!busy && !spi_sck));

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |=> tbl_rvalid);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_rd |=> !tbl_rvalid);

endmodule

bind dgasm_top dgasm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .tbl_rd     (tbl_rd),
  .tbl_rvalid (tbl_rvalid),
  .spi_sck    (spi_sck),
  .spi_sdo    (spi_sdo),
  .spi_cs_n   (spi_cs_n)
);

// File: tb/dgasm_top_tb_top.sv
`timescale 1ns/1ps
module dgasm_top_tb_top;

  localparam int NM   = 3;
  localparam int DW   = 6;
  localparam int DEP  = 64;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy;
  logic [NM-1:0] phase_a = '0, phase_b = '0, fdec_a = '0, fdec_b = '0;
  logic [NM*DW-1:0] dac_a = '0, dac_b = '0;
  logic tbl_wr = 1'b0, tbl_rd = 1'b0;
  logic [4:0] tbl_pair = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] tbl_rdata;
  logic tbl_rvalid, spi_sck, spi_sdo, spi_cs_n;

  always #2 clk = ~clk;

  dgasm_top #(.NUM_MOTORS(NM), .DAC_W(DW), .TBL_DEPTH(DEP),
              .HALF_PERIOD(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .phase_a(phase_a), .phase_b(phase_b), .fdec_a(fdec_a), .fdec_b(fdec_b),
    .dac_a(dac_a), .dac_b(dac_b), .tbl_wr(tbl_wr), .tbl_rd(tbl_rd),
    .tbl_pair(tbl_pair), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .tbl_rvalid(tbl_rvalid), .spi_sck(spi_sck), .spi_sdo(spi_sdo),
    .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Monitor (sole writer of its counters)
  bit   rx_bits [256];
  int   rx_n = 0, cs_rises = 0, viol = 0, lead_bad = 0, lead = 0;
  logic sck_p = 1'b0, sdo_p = 1'b0, cs_p = 1'b1;
  bit   first = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_p && spi_cs_n) cs_rises++;
      if (cs_p && !spi_cs_n) begin lead = 0; first = 1'b1; end
      else if (!spi_cs_n) lead++;
      if (!sck_p && spi_sck) begin
        rx_bits[rx_n % 256] = spi_sdo;
        rx_n++;
        if (first && lead < HALF) lead_bad++;
        first = 1'b0;
      end
      if (spi_sck && sck_p && spi_sdo != sdo_p) viol++;
      if (spi_cs_n && spi_sck) viol++;
      sck_p = spi_sck; sdo_p = spi_sdo; cs_p = spi_cs_n;
    end
  end

  // Watchdog
  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  // Reference model
  int tb_tbl [64];
  bit exp_bits [64];
  int exp_n;
  logic [NM-1:0] s_pa, s_pb, s_fa, s_fb;
  logic [NM*DW-1:0] s_da, s_db;

  function automatic bit src_bit(input int c, input int m);
    if (c == 0) return 1'b0;
    if (c == 1) return 1'b1;
    if (m >= NM) return 1'b0;
    case (c)
      2: return s_pa[m];
      3: return s_pb[m];
      4: return s_fa[m];
      5: return s_fb[m];
      default: begin
        if (c <= 9) return s_da[m*DW + DW-4 + (c-6)];
        return s_db[m*DW + DW-4 + (c-10)];
      end
    endcase
  endfunction

  task automatic compute_exp();
    int m = 0;
    exp_n = 0;
    for (int i = 0; i < DEP; i++) begin
      if (tb_tbl[i] == 15) break;
      if (tb_tbl[i] == 14) m++;
      else begin exp_bits[exp_n] = src_bit(tb_tbl[i], m); exp_n++; end
    end
  endtask

  task automatic prog_table();
    for (int p = 0; p < DEP/2; p++) begin
      @(negedge clk);
      tbl_wr = 1'b1; tbl_pair = 5'(p);
      tbl_wdata = {4'(tb_tbl[2*p+1]), 4'(tb_tbl[2*p])};
    end
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic set_inputs(input int p);
    phase_a = NM'(p * 5 + 1);
    phase_b = NM'(p * 3 + 6);
    fdec_a  = NM'(p * 7 + 2);
    fdec_b  = NM'(p + 5);
    dac_a   = (NM*DW)'(p * 32'h2B5C7 + 32'h1357);
    dac_b   = (NM*DW)'(p * 32'h1D3A9 + 32'h2C4E);
  endtask

  task automatic run_frame(input string rq, input bit disturb);
    int base_n, base_cs, base_v, base_l, nb, cyc;
    s_pa = phase_a; s_pb = phase_b; s_fa = fdec_a; s_fb = fdec_b;
    s_da = dac_a;   s_db = dac_b;
    compute_exp();
    @(negedge clk);
    base_n = rx_n; base_cs = cs_rises; base_v = viol; base_l = lead_bad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && spi_cs_n === 1'b0, "R7", "busy after start",
        int'(busy), 1);
    cyc = 0;
    while (busy === 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 8) begin
        set_inputs(77); start = 1'b1;
      end else if (disturb && cyc == 9) begin
        start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    nb = rx_n - base_n;
    chk(nb == exp_n, rq, "bit count", nb, exp_n);
    if (nb == exp_n) begin
      int bad = 0;
      for (int i = 0; i < exp_n; i++)
        if (rx_bits[(base_n + i) % 256] != exp_bits[i]) bad++;
      chk(bad == 0, rq, "mismatched bits", bad, 0);
    end
    chk(cs_rises - base_cs == 1, "R6", "cs rises per frame",
        cs_rises - base_cs, 1);
    chk(viol == base_v, "R5", "sck/sdo timing violations", viol - base_v, 0);
    chk(lead_bad == base_l, "R6", "short cs lead", lead_bad - base_l, 0);
  endtask

  task automatic read_pair(input int p, input int exp, input string rq);
    @(negedge clk);
    tbl_rd = 1'b1; tbl_pair = 5'(p);
    @(negedge clk);
    tbl_rd = 1'b0;
    chk(tbl_rvalid === 1'b1 && int'(tbl_rdata) == exp, rq, "pair read",
        int'(tbl_rdata), exp);
    @(negedge clk);
    chk(tbl_rvalid === 1'b0, "R9", "valid one cycle", int'(tbl_rvalid), 0);
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) tb_tbl[i] = 15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && spi_sdo === 1'b0 &&
        busy === 1'b0, "R11", "idle outputs after reset",
        int'({spi_cs_n, spi_sck, spi_sdo, busy}), 8);
    read_pair(0, 8'hFF, "R11");
    read_pair(31, 8'hFF, "R11");
    run_frame("R11", 1'b0);

    // Three-driver layout: decay tied 0, tied 1, live (R1 R2 R4)
    begin
      int k = 0;
      for (int d = 0; d < 3; d++) begin
        for (int c = 0; c < 2; c++) begin
          tb_tbl[k] = (d == 0) ? 0 : (d == 1) ? 1 : (c ? 5 : 4); k++;
          for (int b = 3; b >= 0; b--) begin
            tb_tbl[k] = (c ? 10 : 6) + b; k++;
          end
          tb_tbl[k] = c ? 3 : 2; k++;
        end
        if (d < 2) begin tb_tbl[k] = 14; k++; end
      end
    end
    prog_table();
    for (int p = 0; p < 4; p++) begin
      set_inputs(p);
      run_frame("R1", 1'b0);
      chk(exp_n == 36, "R2", "three-driver length", exp_n, 36);
    end
    // R10 / R7: inputs change and start repeats during a frame
    set_inputs(9);
    run_frame("R10", 1'b1);

    // Sweep every bit code against every motor slot (R1 R2 R4)
    set_inputs(3);
    for (int c = 0; c < 14; c++) begin
      for (int m = 0; m <= NM; m++) begin
        for (int i = 0; i < DEP; i++) tb_tbl[i] = 15;
        for (int i = 0; i < m; i++) tb_tbl[i] = 14;
        tb_tbl[m] = c;
        prog_table();
        run_frame((c >= 6) ? "R4" : (m == NM) ? "R2" : "R1", 1'b0);
      end
    end

    // R3: no end code, walks all entries
    for (int i = 0; i < DEP; i++) tb_tbl[i] = (i * 5) % 14;
    prog_table();
    set_inputs(5);
    run_frame("R3", 1'b0);
    chk(exp_n == DEP, "R3", "full-table length", exp_n, DEP);
    // R3: end code in the middle, ones after it ignored
    for (int i = 11; i < DEP; i++) tb_tbl[i] = 1;
    tb_tbl[10] = 15;
    prog_table();
    run_frame("R3", 1'b0);

    // R8 / R9: read-modify-write of one entry (entry 11, high half of pair 5)
    read_pair(5, tb_tbl[11] * 16 + tb_tbl[10], "R9");
    @(negedge clk);
    tbl_wr = 1'b1; tbl_pair = 5'd5; tbl_wdata = {4'd0, 4'(tb_tbl[10])};
    @(negedge clk);
    tbl_wr = 1'b0;
    tb_tbl[11] = 0;
    read_pair(5, tb_tbl[10], "R8");
    read_pair(6, tb_tbl[13] * 16 + tb_tbl[12], "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule